// File: doc/BRIEF.md
# Seven-to-one LVDS lane serializer

This block turns one 21-bit pixel word into four serial lanes that run at seven times the pixel rate. The word is made of six bits each of red, green and blue plus horizontal sync, vertical sync and data enable. Three lanes carry the payload and a fourth lane forwards a clock whose rising edge marks the start of every pixel period. All four lanes are single-ended logic bits, each standing in for one differential pair. A separate flag says when the pairs would be in the high-impedance state.

The block runs entirely on the 7x bit clock. An internal slot timer cuts that clock into pixel periods of seven slots. The word present at the bit-clock edge that closes slot 6 is held and sent during the following period. The lane outputs are gated by three controls: an output enable, a link-lock input and a power-down input. A sleep-select input chooses how the lanes rest while the link is unlocked or powered down. Power-down also clears the timer and the held word, so the lanes restart from a clean frame boundary when it is released.

Top module: `lvds_lane_serializer`

## Requirements
- R1: While reset is held, and in the first pixel period after its release, the held word is zero. With the lanes enabled, locked and powered, every data lane is low and the clock lane shows its slot pattern.
- R2: Slots 0 to 6 of each pixel period carry the clock lane values 1,1,0,0,0,1,1. Slot 0 of the first period begins at the release of reset, and the pattern repeats every seven bit clocks.
- R3: The payload word is packed with red in bits 0-5, green in bits 6-11, blue in bits 12-17, HS in bit 18, VS in bit 19 and DE in bit 20. Data lane k carries word bits 7k to 7k+6 as its lane bits 0 to 6.
- R4: Within a pixel period, slots 0 to 6 of each data lane send lane bits 1, 0, 6, 5, 4, 3, 2, in that order.
- R5: The word sampled at the bit-clock edge that ends slot 6 is sent in the next pixel period, one period of latency. Input values at any other edge have no effect on the lanes.
- R6: When the output enable is low, the high-impedance flag is 1 and all four lanes read 0, whatever the lock and power-down inputs are. When the output enable is high and the block is locked and powered, the flag is 0.
- R7: When the output enable is high and link lock is low, the lanes enter sleep. With sleep select 0, all four lanes are driven low and the flag is 0. With sleep select 1, the flag is 1 and the lanes read 0.
- R8: A low link lock stops neither the slot timer nor the capture of words. A word captured while lock is low is sent in the next period once lock is high again.
- R9: While power-down is high, the lanes follow the sleep rule of R7, the slot timer is held at slot 0 and the held word is cleared. After release, timing restarts exactly as after reset, and words offered during power-down are never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 7x bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_red | input | 6 | Red component of the pixel word |
| pix_grn | input | 6 | Green component of the pixel word |
| pix_blu | input | 6 | Blue component of the pixel word |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| den | input | 1 | Data enable |
| link_lock | input | 1 | Link lock status; low puts the lanes in sleep |
| out_en | input | 1 | Output enable; low flags all lanes high-impedance |
| power_down | input | 1 | Power-down; holds the timer and clears the held word |
| sleep_hiz | input | 1 | Sleep select: 0 drive low, 1 high-impedance |
| lane_data | output | 3 | Serial data lanes, one bit slot per bit clock |
| lane_clk | output | 1 | Forwarded clock lane |
| lane_hiz | output | 1 | High-impedance flag covering all four lanes |

## Verification
The lane outputs come from registers updated on the bit clock, gated by logic that has no registers. A word is therefore due in the seven cycles that start one cycle after the edge closing slot 6. A change on any gating input shows up in the same cycle. The bench counts bit clocks from the release of reset or power-down. It drives each new word at the falling edge before the capture edge, and puts decoy values on the inputs mid-period. It samples every slot one time unit after a falling edge, when registered and gated values have both settled. Each period is swept slot by slot against the expected value for the word loaded one period earlier.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

   // lane bit sent in a given slot: first the pair 1,0 then the rest descending
   function automatic int unsigned slot_bit(int unsigned slot, int unsigned nslots);
      if (slot < 2) return 1 - slot;
      return nslots + 1 - slot;
   endfunction

   // forwarded clock level per slot: high at both ends of the period
   function automatic logic clk_level(int unsigned slot, int unsigned nslots);
      return (slot < 2) || (slot >= nslots - 2);
   endfunction

   typedef enum logic [1:0] {
      DRV_ACTIVE = 2'd0,
      DRV_LOW    = 2'd1,
      DRV_HIZ    = 2'd2
   } drive_mode_e;

endpackage

// File: rtl/lvds_slot_timer.sv
module lvds_slot_timer #(
   parameter int SLOTS  = 7,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   output logic [SLOT_W-1:0] slot,
   output logic              last
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

   assign last = (slot == LAST_SLOT);

   always_ff @(posedge clk) begin
      if (!rst_n || hold) slot <= '0;
      else if (last)      slot <= '0;
      else                slot <= slot + 1'b1;
   end
endmodule

// File: rtl/lvds_word_hold.sv
module lvds_word_hold #(
   parameter int WORD_W = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [WORD_W-1:0] d,
   output logic [WORD_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n || clear) q <= '0;
      else if (load)       q <= d;
   end
endmodule

// File: rtl/lvds_lane_mux.sv
module lvds_lane_mux
   import lvds_ser_pkg::*;
#(
   parameter int LANES  = 3,
   parameter int SLOTS  = 7,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int WORD_W = LANES * SLOTS
) (
   input  logic [WORD_W-1:0] word,
   input  logic [SLOT_W-1:0] slot,
   output logic [LANES-1:0]  lane_bits,
   output logic              clk_bit
);
   logic [SLOTS-1:0] clk_pat;

   genvar s, l;
   generate
      for (s = 0; s < SLOTS; s++) begin : g_clk
         assign clk_pat[s] = clk_level(s, SLOTS);
      end
      for (l = 0; l < LANES; l++) begin : g_lane
         logic [SLOTS-1:0] ordered;
         for (s = 0; s < SLOTS; s++) begin : g_slot
            assign ordered[s] = word[l*SLOTS + slot_bit(s, SLOTS)];
         end
         assign lane_bits[l] = ordered[slot];
      end
   endgenerate

   assign clk_bit = clk_pat[slot];
endmodule

// File: rtl/lvds_out_gate.sv
module lvds_out_gate
   import lvds_ser_pkg::*;
#(
   parameter int LANES = 3
) (
   input  logic             out_en,
   input  logic             link_lock,
   input  logic             power_down,
   input  logic             sleep_hiz,
   input  logic [LANES-1:0] lane_bits,
   input  logic             clk_bit,
   output logic [LANES-1:0] lane_data,
   output logic             lane_clk,
   output logic             lane_hiz
);
   drive_mode_e mode;

   always_comb begin
      if (!out_en)                        mode = DRV_HIZ;
      else if (power_down || !link_lock)  mode = sleep_hiz ? DRV_HIZ : DRV_LOW;
      else                                mode = DRV_ACTIVE;
   end

   always_comb begin
      lane_data = '0;
      lane_clk  = 1'b0;
      lane_hiz  = 1'b0;
      unique case (mode)
         DRV_ACTIVE: begin
            lane_data = lane_bits;
            lane_clk  = clk_bit;
         end
         DRV_HIZ:  lane_hiz = 1'b1;
         default:  ;
      endcase
   end
endmodule

// File: rtl/lvds_lane_serializer.sv
module lvds_lane_serializer #(
   parameter int COLOR_BITS = 6,
   parameter int LANES      = 3,
   parameter int SLOTS      = 7,
   localparam int WORD_W    = 3 * COLOR_BITS + 3,
   localparam int SLOT_W    = $clog2(SLOTS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [COLOR_BITS-1:0] pix_red,
   input  logic [COLOR_BITS-1:0] pix_grn,
   input  logic [COLOR_BITS-1:0] pix_blu,
   input  logic                  hsync,
   input  logic                  vsync,
   input  logic                  den,
   input  logic                  link_lock,
   input  logic                  out_en,
   input  logic                  power_down,
   input  logic                  sleep_hiz,
   output logic [LANES-1:0]      lane_data,
   output logic                  lane_clk,
   output logic                  lane_hiz
);
   generate
      if (WORD_W != LANES * SLOTS) begin : g_bad_fit
         $error("payload width must equal LANES*SLOTS");
      end
      if (SLOTS < 5) begin : g_bad_slots
         $error("slot order and clock pattern need at least five slots");
      end
   endgenerate

   logic [WORD_W-1:0] payload;
   logic [WORD_W-1:0] held;
   logic [SLOT_W-1:0] slot;
   logic              slot_last;
   logic [LANES-1:0]  lane_bits;
   logic              clk_bit;

   assign payload = {den, vsync, hsync, pix_blu, pix_grn, pix_red};

   lvds_slot_timer #(.SLOTS(SLOTS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (power_down),
      .slot  (slot),
      .last  (slot_last)
   );

   lvds_word_hold #(.WORD_W(WORD_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (power_down),
      .load  (slot_last),
      .d     (payload),
      .q     (held)
   );

   lvds_lane_mux #(.LANES(LANES), .SLOTS(SLOTS)) u_mux (
      .word      (held),
      .slot      (slot),
      .lane_bits (lane_bits),
      .clk_bit   (clk_bit)
   );

   lvds_out_gate #(.LANES(LANES)) u_gate (
      .out_en     (out_en),
      .link_lock  (link_lock),
      .power_down (power_down),
      .sleep_hiz  (sleep_hiz),
      .lane_bits  (lane_bits),
      .clk_bit    (clk_bit),
      .lane_data  (lane_data),
      .lane_clk   (lane_clk),
      .lane_hiz   (lane_hiz)
   );
endmodule

// File: rtl/lvds_lane_serializer_chk.sv
module lvds_lane_serializer_chk #(
   parameter int LANES  = 3,
   parameter int SLOTS  = 7,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             red_lsb,
   input logic             link_lock,
   input logic             out_en,
   input logic             power_down,
   input logic             sleep_hiz,
   input logic [LANES-1:0] lane_data,
   input logic             lane_clk,
   input logic             lane_hiz
);
   logic [SLOT_W-1:0] shadow;
   logic              primed;
   logic              active;

   assign active = out_en && link_lock && !power_down;

   always_ff @(posedge clk) begin
      if (!rst_n || power_down) begin
         shadow <= '0;
         primed <= 1'b0;
      end else if (shadow == SLOT_W'(SLOTS - 1)) begin
         shadow <= '0;
         primed <= 1'b1;
      end else begin
         shadow <= shadow + 1'b1;
      end
   end

   assert_hiz_when_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> (lane_hiz && lane_data == '0 && !lane_clk));

   assert_driven_when_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> !lane_hiz);

   assert_sleep_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && (!link_lock || power_down) && !sleep_hiz)
         |-> (!lane_hiz && lane_data == '0 && !lane_clk));

   assert_sleep_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en && (!link_lock || power_down) && sleep_hiz)
         |-> (lane_hiz && lane_data == '0 && !lane_clk));

   assert_clk_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (lane_clk == ((shadow < 2) || (shadow >= SLOT_W'(SLOTS - 2)))));

   assert_one_period_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && primed && shadow == SLOT_W'(1)) |-> (lane_data[0] == $past(red_lsb, 2)));
endmodule

bind lvds_lane_serializer lvds_lane_serializer_chk #(.LANES(LANES), .SLOTS(SLOTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .red_lsb    (pix_red[0]),
   .link_lock  (link_lock),
   .out_en     (out_en),
   .power_down (power_down),
   .sleep_hiz  (sleep_hiz),
   .lane_data  (lane_data),
   .lane_clk   (lane_clk),
   .lane_hiz   (lane_hiz)
);

// File: tb/lvds_lane_serializer_test.sv
module lvds_lane_serializer_test;
   localparam int M_ACT = 0, M_OE = 1, M_SLP_LO = 2, M_SLP_Z = 3, M_OE_SLP = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [5:0] pix_red, pix_grn, pix_blu;
   logic       hsync, vsync, den;
   logic       link_lock, out_en, power_down, sleep_hiz;
   logic [2:0] lane_data;
   logic       lane_clk, lane_hiz;

   int n_tests = 0;
   int n_fail  = 0;
   logic [20:0] prev;

   always #5 clk = ~clk;

   lvds_lane_serializer uut (
      .clk(clk), .rst_n(rst_n),
      .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu),
      .hsync(hsync), .vsync(vsync), .den(den),
      .link_lock(link_lock), .out_en(out_en), .power_down(power_down),
      .sleep_hiz(sleep_hiz),
      .lane_data(lane_data), .lane_clk(lane_clk), .lane_hiz(lane_hiz)
   );

   // word layout per R3: red 0-5, green 6-11, blue 12-17, HS 18, VS 19, DE 20
   task automatic drive_word(input logic [20:0] w);
      pix_red = w[5:0];
      pix_grn = w[11:6];
      pix_blu = w[17:12];
      hsync   = w[18];
      vsync   = w[19];
      den     = w[20];
   endtask

   task automatic set_mode(input int m);
      out_en    = !(m == M_OE || m == M_OE_SLP);
      link_lock = !(m == M_SLP_LO || m == M_SLP_Z || m == M_OE_SLP);
      sleep_hiz = (m == M_SLP_Z);
   endtask

   // expected {hiz, clk, lane2, lane1, lane0}
   function automatic logic [4:0] expect_out(logic [20:0] w, int s, int m);
      int order [7]       = '{1, 0, 6, 5, 4, 3, 2};
      logic clkpat [7]    = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
      int o;
      if (m == M_OE || m == M_OE_SLP || m == M_SLP_Z) return 5'b10000;
      if (m == M_SLP_LO) return 5'b00000;
      o = order[s];
      return {1'b0, clkpat[s], w[14 + o], w[7 + o], w[o]};
   endfunction

   task automatic check(input string req, input logic [4:0] exp_v);
      logic [4:0] act;
      act = {lane_hiz, lane_clk, lane_data};
      n_tests++;
      if (act !== exp_v) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b (hiz,clk,lanes)", req, act, exp_v);
      end
   endtask

   // one pixel period: check each slot against prev, decoy mid-period, load nxt at slot 6
   task automatic run_period(input logic [20:0] nxt, input int m, input string req);
      for (int s = 0; s < 7; s++) begin
         if (s == 0) set_mode(m);
         if (s == 3) drive_word(~nxt);
         if (s == 6) drive_word(nxt);
         #1;
         check(req, expect_out(prev, s, m));
         @(posedge clk);
         @(negedge clk);
      end
      prev = nxt;
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [20:0] lfsr;
      rst_n = 1'b0;
      power_down = 1'b0;
      drive_word(21'h0);
      set_mode(M_ACT);
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      check("R1 reset", 5'b01000);
      rst_n = 1'b1;
      prev = '0;

      run_period(21'h000001, M_ACT, "R1 R2");
      for (int b = 1; b < 21; b++)
         run_period(21'(1) << b, M_ACT, "R3 R4");
      run_period(21'h000000, M_ACT, "R3 R4");
      run_period(21'h1FFFFF, M_ACT, "R5");
      run_period(21'h155555, M_ACT, "R5");
      run_period(21'h0AAAAA, M_ACT, "R5");
      lfsr = 21'h13579;
      for (int k = 0; k < 6; k++) begin
         lfsr = {lfsr[19:0], lfsr[20] ^ lfsr[18]} ^ 21'h0C3A5;
         run_period(lfsr, M_ACT, "R2 R5");
      end

      run_period(21'h0F0F0F, M_OE,     "R6");
      run_period(21'h1234A5, M_ACT,    "R6");
      run_period(21'h0ABCDE, M_SLP_LO, "R7");
      run_period(21'h1C3C3C, M_SLP_Z,  "R7");
      run_period(21'h05A5A5, M_OE_SLP, "R6");
      run_period(21'h16E01B, M_ACT,    "R8");
      run_period(21'h000000, M_ACT,    "R8");

      // power-down: sleep rule, timer hold, word clear
      set_mode(M_ACT);
      drive_word(21'h1FFFFF);
      power_down = 1'b1;
      #1;
      check("R9 sleep low", 5'b00000);
      @(posedge clk); @(negedge clk);
      sleep_hiz = 1'b1;
      #1;
      check("R9 sleep hiz", 5'b10000);
      @(posedge clk); @(negedge clk);
      out_en = 1'b0;
      #1;
      check("R6 over power-down", 5'b10000);
      repeat (5) begin @(posedge clk); @(negedge clk); end
      set_mode(M_ACT);
      power_down = 1'b0;
      prev = '0;
      run_period(21'h0D2C4B, M_ACT, "R9 restart");
      run_period(21'h000000, M_ACT, "R9");

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule